// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return addresses of a small microcontroller core. When a subroutine call executes, or when an interrupt forces a branch, the core's sequencer raises a push strobe with the program counter value to keep. When one of the three return-type instructions executes, the sequencer raises a pop strobe. The block always presents the most recently saved address that is still live. The sequencer reloads its program counter from that address on a return.

The storage is a small register file kept apart from program and data memory. Its pointer is internal and has no read or write path for software. Capacity is eight entries by default. The pointer counts modulo the depth and reports neither overflow nor underflow. A ninth push in a row therefore replaces the oldest entry. A pop with nothing pushed wraps backwards and exposes whichever slot it then addresses. A reset moves only the pointer back to slot zero and leaves the stored addresses as they were.

Top module: `ret_addr_stack`

## Requirements
- R1: A push stores `push_pc_i`, and `top_pc_o` equals that value once the capturing clock edge has passed.
- R2: Pops return addresses in the reverse of the order they were pushed, one entry per pop strobe.
- R3: The pointer wraps modulo the depth (8 by default). After nine pushes in a row, the ninth value occupies the first push's slot, and the first value can no longer be reached by any number of pops.
- R4: A pop with no live entries is not blocked. The pointer steps back from slot 0 to slot 7, and `top_pc_o` shows what slot 6 holds.
- R5: When push and pop are raised in the same cycle, only the push takes effect. The new value becomes the top, and the entry below it is the previous top.
- R6: Asserting `rst_n` low sets the pointer to slot 0 without altering any stored entry. `top_pc_o` then shows slot 7's contents, and the next push lands in slot 0.
- R7: While neither strobe is raised, `top_pc_o` and the pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_i | input | 1 | Save `push_pc_i` on top of the stack (call or interrupt entry) |
| pop_i | input | 1 | Discard the top entry (any return-type instruction) |
| push_pc_i | input | 13 | Program counter value to save |
| top_pc_o | output | 13 | Address currently on top of the stack |

## Verification
The storage and the pointer are both registered, and the read path is combinational. Every push or pop therefore shows up on `top_pc_o` right after the single clock edge that captures the strobe. Each bench task drives a strobe on a falling edge and keeps it through exactly one rising edge. The task clears the strobe and samples `top_pc_o` at the next falling edge, so the expected value is due at that point and not earlier. After `rst_n` rises, the reset synchronizer holds the pointer cleared for two more rising edges. The bench therefore waits three cycles before its first post-reset strobe.

// File: rtl/ras_pkg.sv
package ras_pkg;

  localparam int RAS_DEPTH_DEF = 8;
  localparam int RAS_PC_W_DEF  = 13;

  typedef enum logic [1:0] {
    RAS_HOLD = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2
  } ras_op_e;

endpackage

// File: rtl/ras_rst_sync.sv
module ras_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = RAS_DEPTH_DEF,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ras_op_e       op,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] top_idx
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  // next-state: modulo counter, natural binary wrap
  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    case (op)
      RAS_PUSH: begin
        ptr_d  = ptr_q + PW'(1);
        ptr_en = 1'b1;
      end
      RAS_POP: begin
        ptr_d  = ptr_q - PW'(1);
        ptr_en = 1'b1;
      end
      default: begin
        ptr_d  = ptr_q;
        ptr_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign wr_idx  = ptr_q;
  assign top_idx = ptr_q - PW'(1);

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 13,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_idx,
  input  logic [PC_W-1:0] wr_data,
  input  logic [PW-1:0]   rd_idx,
  output logic [PC_W-1:0] rd_data
);

  logic [PC_W-1:0] slot_q [DEPTH];

  // one register per slot, no reset: contents survive a pointer reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == PW'(g));

    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == PW'(i)) begin
        rd_data = slot_q[i];
      end
    end
  end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int DEPTH = RAS_DEPTH_DEF,
  parameter int PC_W  = RAS_PC_W_DEF,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] push_pc_i,
  output logic [PC_W-1:0] top_pc_o
);

  logic          rst_sync_n;
  ras_op_e       op;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] top_idx;
  logic          wr_en;

  ras_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // push outranks pop when both strobes arrive together
  always_comb begin
    if (push_i) begin
      op = RAS_PUSH;
    end else if (pop_i) begin
      op = RAS_POP;
    end else begin
      op = RAS_HOLD;
    end
  end

  assign wr_en = (op == RAS_PUSH);

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .op      (op),
    .wr_idx  (wr_idx),
    .top_idx (top_idx)
  );

  ras_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (push_pc_i),
    .rd_idx  (top_idx),
    .rd_data (top_pc_o)
  );

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 13,
  localparam int PW   = $clog2(DEPTH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push_i,
  input logic            pop_i,
  input logic [PC_W-1:0] push_pc_i,
  input logic [PC_W-1:0] top_pc_o,
  input logic [PW-1:0]   ptr
);

  p_push_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_pc_o == $past(push_pc_i));

  p_pop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> ptr == PW'($past(ptr) - PW'(1)));

  p_push_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> ptr == PW'($past(ptr) + PW'(1)));

  p_push_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> (top_pc_o == $past(push_pc_i)) &&
                          (ptr == PW'($past(ptr) + PW'(1))));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(top_pc_o) && $stable(ptr));

endmodule

bind ret_addr_stack ras_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_i    (push_i),
  .pop_i     (pop_i),
  .push_pc_i (push_pc_i),
  .top_pc_o  (top_pc_o),
  .ptr       (wr_idx)
);

// File: tb/ret_addr_stack_tb.sv
`timescale 1ns/1ps
module ret_addr_stack_tb;

  logic        clk;
  logic        rst_n;
  logic        push_i;
  logic        pop_i;
  logic [12:0] push_pc_i;
  logic [12:0] top_pc_o;

  int checks;
  int failures;

  ret_addr_stack u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .push_pc_i (push_pc_i),
    .top_pc_o  (top_pc_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [12:0] exp);
    checks++;
    if (top_pc_o !== exp) begin
      failures++;
      $display("FAIL %s: top_pc_o actual=%h expected=%h", req, top_pc_o, exp);
    end
  endtask

  // one strobe held through exactly one rising edge, sampled at the next falling edge
  task automatic step(input logic ps, input logic pp, input logic [12:0] pc);
    @(negedge clk);
    push_i    = ps;
    pop_i     = pp;
    push_pc_i = pc;
    @(negedge clk);
    push_i = 1'b0;
    pop_i  = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_push_one();
    do_reset();
    step(1, 0, 13'h0AB); check("R1", 13'h0AB);
    step(1, 0, 13'h0CD); check("R1", 13'h0CD);
    step(0, 1, 13'h000); check("R2", 13'h0AB);
  endtask

  task automatic t_lifo();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 13'h100 + 13'(i)); check("R1", 13'h100 + 13'(i));
    end
    for (int j = 1; j < 8; j++) begin
      step(0, 1, 13'h000); check("R2", 13'h107 - 13'(j));
    end
  endtask

  task automatic t_reset_keep();
    // slots 0..7 hold 0x100..0x107
    do_reset();
    check("R6", 13'h107);
    step(1, 0, 13'h1FF); check("R6", 13'h1FF);
    step(0, 1, 13'h000); check("R6", 13'h107);
  endtask

  task automatic t_empty_pop();
    // slot0=0x1FF, slots 1..7 = 0x101..0x107
    do_reset();
    step(0, 1, 13'h000); check("R4", 13'h106);
    step(0, 1, 13'h000); check("R4", 13'h105);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 9; i++) begin
      step(1, 0, 13'h200 + 13'(i));
    end
    check("R3", 13'h208);
    for (int j = 1; j < 8; j++) begin
      step(0, 1, 13'h000); check("R3", 13'h208 - 13'(j));
    end
    step(0, 1, 13'h000); check("R3", 13'h208);
  endtask

  task automatic t_push_pop();
    do_reset();
    step(1, 0, 13'h111); check("R5", 13'h111);
    step(1, 0, 13'h222); check("R5", 13'h222);
    step(1, 1, 13'h333); check("R5", 13'h333);
    step(0, 1, 13'h000); check("R5", 13'h222);
    step(0, 1, 13'h000); check("R5", 13'h111);
  endtask

  task automatic t_idle();
    do_reset();
    step(1, 0, 13'h0AA); check("R7", 13'h0AA);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      push_pc_i = 13'h1555 ^ 13'(k);
      check("R7", 13'h0AA);
    end
  endtask

  initial begin
    checks    = 0;
    failures  = 0;
    rst_n     = 1'b0;
    push_i    = 1'b0;
    pop_i     = 1'b0;
    push_pc_i = '0;
    t_push_one();
    t_lifo();
    t_reset_keep();
    t_empty_pop();
    t_wrap();
    t_push_pop();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule